// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Queue

This block takes an asynchronous serial line, samples it on a 16x oversampling clock enable, and turns each character it recognises into a parallel byte. Each byte carries its own flags for a parity mismatch, a bad stop bit and a line break. The receiver waits for a low level on the idle line. It checks the line again near the middle of the start bit and drops the start if the line has gone high by then. It then takes five to eight data bits, least significant bit first, followed by an optional parity bit and one stop bit.

Every completed character is written, together with its three flags, into a sixteen-entry first-in first-out queue. The reading side sees the oldest character and its own flags at all times. It removes that character with a one-cycle read strobe. When a character completes while the queue is full, the new character is thrown away, the stored ones are kept, and a one-cycle overrun pulse is given instead. Two level outputs report that the queue holds data: one intended for the processor and one intended as a DMA request.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset the queue is empty: `data_ready`, `rx_req` and `ovr_pulse` are low.
- R2: `cfg_len` selects the data length (0 = 5, 1 = 6, 2 = 7, 3 = 8 bits). The bits are received least significant first and placed at `rd_data[0]` upward. Unused upper bits read as zero.
- R3: With `cfg_par_en` high, one parity bit follows the data. `cfg_par_odd` = 0 expects even parity and 1 expects odd parity, counted over the data and the parity bit together. A mismatch sets `rd_perr` for that character. With `cfg_par_en` low, no parity bit is expected and `rd_perr` stays 0.
- R4: A character whose stop bit is sampled low, and which is not a break, is stored with its data and with `rd_ferr` set.
- R5: A low level that has returned high when it is checked again near the middle of the start bit produces no character.
- R6: Each data bit is sampled once, a full bit time (16 ticks) after the previous sample point, with the first sample a bit time after the start-bit check. Disturbances in the first three ticks of a bit have no effect.
- R7: When the start bit, all data bits, the parity bit (if any) and the stop bit are all sampled low, exactly one character is stored, with `rd_data` = 0, `rd_brk` = 1, `rd_perr` = 0 and `rd_ferr` = 0. No further character starts until the line has been sampled high.
- R8: The queue holds 16 characters in arrival order. `rd_data`, `rd_perr`, `rd_ferr` and `rd_brk` always describe the character at the head.
- R9: A character that completes while 16 characters are stored is dropped, the stored characters are unchanged, and `ovr_pulse` is high for exactly one cycle. Fullness is judged before any read in the same cycle.
- R10: `data_ready` and `rx_req` are high exactly while the queue holds a character. `rd_en` on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit time |
| rx_line | input | 1 | Serial input, idle high |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_en | input | 1 | Remove the head character |
| rd_data | output | 8 | Data of the head character |
| rd_perr | output | 1 | Parity flag of the head character |
| rd_ferr | output | 1 | Stop-bit flag of the head character |
| rd_brk | output | 1 | Break flag of the head character |
| data_ready | output | 1 | Queue is not empty |
| rx_req | output | 1 | DMA-style request, queue is not empty |
| ovr_pulse | output | 1 | One-cycle pulse when a character is dropped |

## Verification
The bench sends a short dip in the line. A receiver that skipped the mid-start check would turn that dip into a stray 0xFF-like character. It sends data bits whose first ticks are inverted. A receiver sampling near the bit edge would return corrupted bytes. It holds the line low for two frames, which catches a design that stores a run of zero characters or drops the break flag. It also writes seventeen characters with no reads, so a queue that overwrote its oldest entry or misplaced its pointers would return the wrong sequence or miss the overrun pulse. Reads on an empty queue are tried as well.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned CHAR_W = 8;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_char_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

endpackage

// File: rtl/rxq_deser.sv
module rxq_deser
    import rxq_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx_line,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    output logic       push_o,
    output rx_char_t   char_o
);
    localparam int unsigned CW       = $clog2(OVS);
    localparam logic [CW-1:0] MID_T  = CW'(OVS/2 - 2);
    localparam logic [CW-1:0] LAST_T = CW'(OVS - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [1:0]        sync;
        logic [CW-1:0]     cnt;
        logic [2:0]        idx;
        logic [CHAR_W-1:0] shreg;
        logic              zero;
        logic              pbit;
        logic              push;
        rx_char_t          chr;
    } deser_t;

    deser_t s_q, s_d;
    logic   line_s;
    logic [2:0] last_idx;

    assign line_s   = s_q.sync[1];
    assign last_idx = 3'(cfg_len) + 3'd4;

    always_comb begin
        s_d      = s_q;
        s_d.push = 1'b0;
        s_d.sync = {s_q.sync[0], rx_line};
        if (tick16) begin
            unique case (s_q.st)
                RX_IDLE: begin
                    if (!line_s) begin
                        s_d.st  = RX_START;
                        s_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (s_q.cnt == MID_T) begin
                        if (line_s) begin
                            s_d.st = RX_IDLE;
                        end else begin
                            s_d.st    = RX_DATA;
                            s_d.cnt   = '0;
                            s_d.idx   = '0;
                            s_d.shreg = '0;
                            s_d.zero  = 1'b1;
                            s_d.pbit  = 1'b0;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (s_q.cnt == LAST_T) begin
                        s_d.cnt              = '0;
                        s_d.shreg[s_q.idx]   = line_s;
                        s_d.zero             = s_q.zero & ~line_s;
                        if (s_q.idx == last_idx) begin
                            s_d.st = cfg_par_en ? RX_PAR : RX_STOP;
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (s_q.cnt == LAST_T) begin
                        s_d.cnt  = '0;
                        s_d.pbit = line_s;
                        s_d.zero = s_q.zero & ~line_s;
                        s_d.st   = RX_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (s_q.cnt == LAST_T) begin
                        s_d.cnt  = '0;
                        s_d.push = 1'b1;
                        if (!line_s && s_q.zero) begin
                            s_d.chr = '{data: '0, perr: 1'b0, ferr: 1'b0, brk: 1'b1};
                            s_d.st  = RX_HOLD;
                        end else begin
                            s_d.chr.data = s_q.shreg;
                            s_d.chr.perr = cfg_par_en & (^s_q.shreg ^ s_q.pbit ^ cfg_par_odd);
                            s_d.chr.ferr = ~line_s;
                            s_d.chr.brk  = 1'b0;
                            s_d.st       = RX_IDLE;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_HOLD: begin
                    if (line_s) s_d.st = RX_IDLE;
                end
                default: s_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= RX_IDLE;
            s_q.sync <= 2'b11;
        end else begin
            s_q <= s_d;
        end
    end

    assign push_o = s_q.push;
    assign char_o = s_q.chr;

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  rx_char_t                   char_i,
    input  logic                       pop_i,
    output rx_char_t                   head_o,
    output logic [$clog2(DEPTH+1)-1:0] fill_o,
    output logic                       ovr_o
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned NW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);
    localparam logic [NW-1:0] FULL_N = NW'(DEPTH);

    typedef struct packed {
        rx_char_t [DEPTH-1:0] mem;
        logic [AW-1:0]        wr;
        logic [AW-1:0]        rd;
        logic [NW-1:0]        cnt;
        logic                 ovr;
    } store_t;

    store_t f_q, f_d;
    logic   do_push, do_pop, is_full;

    assign is_full = (f_q.cnt == FULL_N);
    assign do_push = push_i & ~is_full;
    assign do_pop  = pop_i & (f_q.cnt != '0);

    always_comb begin
        f_d     = f_q;
        f_d.ovr = push_i & is_full;
        if (do_push) begin
            f_d.mem[f_q.wr] = char_i;
            f_d.wr          = (f_q.wr == LAST_A) ? '0 : f_q.wr + 1'b1;
        end
        if (do_pop) begin
            f_d.rd = (f_q.rd == LAST_A) ? '0 : f_q.rd + 1'b1;
        end
        unique case ({do_push, do_pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head_o = f_q.mem[f_q.rd];
    assign fill_o = f_q.cnt;
    assign ovr_o  = f_q.ovr;

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
    import rxq_pkg::*;
#(
    parameter int unsigned OVS   = 16,
    parameter int unsigned DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx_line,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic       data_ready,
    output logic       rx_req,
    output logic       ovr_pulse
);
    localparam int unsigned NW = $clog2(DEPTH + 1);

    logic          new_push;
    rx_char_t      new_char;
    rx_char_t      head;
    logic [NW-1:0] fill_lvl;

    rxq_deser #(.OVS(OVS)) u_deser (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick16      (tick16),
        .rx_line     (rx_line),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .push_o      (new_push),
        .char_o      (new_char)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (new_push),
        .char_i (new_char),
        .pop_i  (rd_en),
        .head_o (head),
        .fill_o (fill_lvl),
        .ovr_o  (ovr_pulse)
    );

    assign rd_data    = head.data;
    assign rd_perr    = head.perr;
    assign rd_ferr    = head.ferr;
    assign rd_brk     = head.brk;
    assign data_ready = (fill_lvl != '0);
    assign rx_req     = data_ready;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int unsigned DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rd_en,
    input logic [7:0]                 rd_data,
    input logic                       rd_perr,
    input logic                       rd_ferr,
    input logic                       rd_brk,
    input logic                       data_ready,
    input logic                       ovr_pulse,
    input logic [$clog2(DEPTH+1)-1:0] fill
);
    // R7: a break entry carries zero data and no other flag
    assert_brk_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && rd_brk) |-> (rd_data == 8'h00 && !rd_perr && !rd_ferr));

    // R8: the head stays put while nothing is read
    assert_head_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && !rd_en) |=> (data_ready && $stable(rd_data) && $stable(rd_perr)
                                     && $stable(rd_ferr) && $stable(rd_brk)));

    // R8: never more than DEPTH stored
    assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= ($clog2(DEPTH+1))'(DEPTH));

    // R9: overrun only when the queue was full
    assert_ovr_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pulse |-> $past(fill == ($clog2(DEPTH+1))'(DEPTH)));

    // R9: overrun pulse lasts one cycle
    assert_ovr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pulse |=> !ovr_pulse);

    // R10: a read on an empty queue cannot lower anything
    assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0 && rd_en) |=> (fill <= 1));

endmodule

bind serial_rx_queue rxq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rd_perr    (rd_perr),
    .rd_ferr    (rd_ferr),
    .rd_brk     (rd_brk),
    .data_ready (data_ready),
    .ovr_pulse  (ovr_pulse),
    .fill       (fill_lvl)
);

// File: tb/sim_serial_rx_queue.sv
module sim_serial_rx_queue;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk, data_ready, rx_req, ovr_pulse;

    int n_run = 0;
    int n_fail = 0;
    int ovr_seen = 0;
    bit auto_read = 1'b1;
    bit finished = 1'b0;
    logic [10:0] expq[$];

    always #4 clk = ~clk;

    serial_rx_queue u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_en(rd_en), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
        .rd_brk(rd_brk), .data_ready(data_ready), .rx_req(rx_req), .ovr_pulse(ovr_pulse)
    );

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div    = (div + 1) % 4;
            tick16 = (div == 0);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop and compare against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (ovr_pulse) ovr_seen++;
            if (rd_en) begin
                rd_en = 1'b0;
            end else if (auto_read && data_ready) begin
                if (expq.size() == 0) begin
                    check("R8 unexpected char", {21'd0, rd_data, rd_perr, rd_ferr, rd_brk}, 32'hFFFF);
                end else begin
                    check("R2/R3/R4/R7/R8 head", {21'd0, rd_data, rd_perr, rd_ferr, rd_brk},
                          {21'd0, expq.pop_front()});
                end
                rd_en = 1'b1;
            end
        end
    end

    task automatic ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!tick16) @(posedge clk);
        end
    endtask

    task automatic drive(input logic v, input int n);
        @(negedge clk);
        rx_line = v;
        ticks(n);
    endtask

    // send one frame; push the expected entry when stored is set
    task automatic send(input logic [7:0] d, input logic [1:0] len, input bit pen, input bit odd,
                        input bit bad_par, input bit stop_low, input bit glitch, input bit stored);
        int nb = int'(len) + 5;
        logic [7:0] md = d & ((8'd1 << nb) - 8'd1);
        logic pb = (^md) ^ odd;
        bit perr_e;
        if (bad_par) pb = ~pb;
        perr_e = pen && bad_par;
        cfg_len = len; cfg_par_en = pen; cfg_par_odd = odd;
        if (stored) expq.push_back({md, perr_e, stop_low, 1'b0});
        drive(1'b0, 16);
        for (int i = 0; i < nb; i++) begin
            if (glitch) begin
                drive(~md[i], 3);
                drive(md[i], 13);
            end else begin
                drive(md[i], 16);
            end
        end
        if (pen) drive(pb, 16);
        if (stop_low) begin
            drive(1'b0, 10);
            drive(1'b1, 6);
        end else begin
            drive(1'b1, 16);
        end
        drive(1'b1, 4);
    endtask

    task automatic drain(input string req);
        int t = 0;
        while ((expq.size() != 0 || data_ready) && t < 4000) begin
            @(negedge clk);
            t++;
        end
        check(req, expq.size(), 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        check("R1 data_ready", data_ready, 0);
        check("R1 rx_req", rx_req, 0);
        check("R1 ovr_pulse", ovr_pulse, 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 20);

        // R2: every length
        send(8'hA5, 2'd3, 0, 0, 0, 0, 0, 1);
        send(8'hFF, 2'd0, 0, 0, 0, 0, 0, 1);
        send(8'h2B, 2'd1, 0, 0, 0, 0, 0, 1);
        send(8'h55, 2'd2, 0, 0, 0, 0, 0, 1);
        drain("R2 lengths");

        // R3: parity modes
        send(8'h37, 2'd3, 1, 0, 0, 0, 0, 1);
        send(8'h37, 2'd3, 1, 1, 0, 0, 0, 1);
        send(8'h81, 2'd3, 1, 0, 1, 0, 0, 1);
        send(8'h0C, 2'd2, 1, 1, 1, 0, 0, 1);
        send(8'h0C, 2'd3, 0, 1, 1, 0, 0, 1);
        drain("R3 parity");

        // R4: stop bit low
        send(8'h6E, 2'd3, 0, 0, 0, 1, 0, 1);
        drive(1'b1, 20);
        drain("R4 framing");

        // R5: false start
        drive(1'b0, 4);
        drive(1'b1, 40);
        check("R5 no char after dip", data_ready, 0);
        drain("R5 false start");

        // R6: edge disturbances ignored
        send(8'hC3, 2'd3, 1, 0, 0, 0, 1, 1);
        send(8'h5A, 2'd3, 0, 0, 0, 0, 1, 1);
        drain("R6 mid-bit sampling");

        // R7: break, then a normal character
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        expq.push_back({8'h00, 1'b0, 1'b0, 1'b1});
        drive(1'b0, 16 * 22);
        drive(1'b1, 20);
        drain("R7 single break entry");
        send(8'h3C, 2'd3, 0, 0, 0, 0, 0, 1);
        drain("R7 recovery");

        // R8/R9: fill, then overflow by one
        auto_read = 1'b0;
        ovr_seen  = 0;
        for (int i = 0; i < 17; i++)
            send(8'(i * 13 + 1), 2'd3, 0, 0, 0, 0, 0, (i < 16));
        ticks(4);
        check("R9 overrun pulses", ovr_seen, 1);
        check("R10 data_ready full", data_ready, 1);
        check("R10 rx_req full", rx_req, 1);
        auto_read = 1'b1;
        drain("R8 order kept, R9 new char dropped");
        check("R10 rx_req empty", rx_req, 0);

        // R10: read on empty queue
        auto_read = 1'b0;
        @(negedge clk);
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 still empty", data_ready, 0);
        auto_read = 1'b1;
        send(8'h99, 2'd3, 0, 0, 0, 0, 0, 1);
        drain("R10 after empty read");

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule